// File: doc/BRIEF.md
# Masked Vector Register Unit

This unit holds a bank of vector registers and runs one vector instruction at a time on them. It moves whole vectors between a register and a contiguous block of memory, adds two vectors element by element, or adds them under a per-element predicate taken from a 64-bit scalar value. The memory side moves B elements per beat. A vector therefore needs VLEN/B beats, and the arithmetic processes B lanes per cycle.

A decoded instruction arrives on the command port together with the scalar mask value. The unit accepts it only while it is idle, as shown by `cmd_ready`. Memory reads are pipelined, with one request per cycle and data returned one cycle after each request. A single-cycle `done` pulse marks the end of each instruction. Vector contents can be seen only by storing them back to memory.

Top module: `vru_top`

## Requirements
- R1: While reset is held and right after it, `cmd_ready` is 1 and both `done` and `mem_req` are 0.
- R2: A command is taken only when `cmd_valid` and `cmd_ready` are both 1 at a rising edge. `cmd_ready` stays 0 from acceptance until the `done` cycle. A `cmd_valid` raised while busy has no effect on any register.
- R3: Load (`cmd_op` = 2'b00) fills register `cmd_dst` with element i taken from address `cmd_base`+i. Read data on `mem_rdata` arrives one cycle after its request, and lane l (bits l*EW+EW-1 down to l*EW) holds address `mem_addr`+l.
- R4: Store (`cmd_op` = 2'b01) writes all VLEN elements of register `cmd_srca` to addresses `cmd_base`..`cmd_base`+VLEN-1, with `mem_we` = 1 and the same lane layout on `mem_wdata`.
- R5: A load or store issues exactly VLEN/B requests on consecutive cycles. They start at `cmd_base` and `mem_addr` advances by B each beat. Add operations issue no requests.
- R6: Add (`cmd_op` = 2'b10) sets dst[i] = srcA[i] + srcB[i] modulo 2^EW for every i.
- R7: Conditional add (`cmd_op` = 2'b11) applies the R6 sum to element i only where bit i of `cmd_mask` is 1. Elements whose mask bit is 0 keep their previous destination value.
- R8: `done` is a one-cycle pulse. For store, add and conditional add it appears VLEN/B rising edges after the accepting edge. For load it appears VLEN/B+1 edges after the accepting edge.
- R9: A destination register may equal one or both source registers. Each element then gets the sum of the old source values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction present |
| cmd_op | input | 2 | 00 load, 01 store, 10 add, 11 conditional add |
| cmd_dst | input | 3 | Destination register |
| cmd_srca | input | 3 | First source (also the store source) |
| cmd_srcb | input | 3 | Second source |
| cmd_base | input | 16 | Memory base address of the block |
| cmd_mask | input | 64 | Per-element predicate for conditional add |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 write beat, 0 read beat |
| mem_addr | output | 16 | Address of lane 0 of the beat |
| mem_wdata | output | 128 | Store data, B lanes of EW bits |
| mem_rdata | input | 128 | Read data, one cycle after a read request |
| done | output | 1 | Instruction finished pulse |

## Verification
The assertions rely on memory returning read data exactly one cycle after a read request, and on reset being applied before the first instruction. The bench's memory model answers with that fixed latency. It keeps every vector block inside its 1024-word array, so beat addresses never wrap. The bench raises an interfering command only while the unit is busy and drops it before the `done` cycle, so that command is never taken.

// File: rtl/vru_pkg.sv
package vru_pkg;
  typedef enum logic [1:0] {
    OP_VLD   = 2'b00,
    OP_VST   = 2'b01,
    OP_VADD  = 2'b10,
    OP_VCADD = 2'b11
  } vop_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_RUN   = 2'b01,
    S_DRAIN = 2'b10
  } vst_e;

  function automatic int beat_count(input int vlen, input int lanes);
    return vlen / lanes;
  endfunction
endpackage

// File: rtl/vru_rf.sv
module vru_rf #(
  parameter int NREG = 8,
  parameter int VLEN = 64,
  parameter int EW   = 16,
  parameter int B    = 8,
  parameter int RW   = 3,
  parameter int GW   = 3
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RW-1:0]   widx,
  input  logic [GW-1:0]   wgrp,
  input  logic [B-1:0]    wen,
  input  logic [B*EW-1:0] wdata,
  input  logic [RW-1:0]   ra_idx,
  input  logic [RW-1:0]   rb_idx,
  input  logic [GW-1:0]   rgrp,
  output logic [B*EW-1:0] ra_data,
  output logic [B*EW-1:0] rb_data
);
  localparam int EIW = $clog2(VLEN);

  logic [EW-1:0] store_q [NREG][VLEN];

  function automatic logic [EIW-1:0] eidx(input logic [GW-1:0] g, input int l);
    return EIW'(int'(g) * B + l);
  endfunction

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < B; l++) begin
        if (wen[l]) store_q[widx][eidx(wgrp, l)] <= wdata[l*EW +: EW];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < B; l++) begin
      ra_data[l*EW +: EW] = store_q[ra_idx][eidx(rgrp, l)];
      rb_data[l*EW +: EW] = store_q[rb_idx][eidx(rgrp, l)];
    end
  end
endmodule

// File: rtl/vru_lanes.sv
module vru_lanes #(
  parameter int EW = 16,
  parameter int B  = 8
) (
  input  logic [B*EW-1:0] opa,
  input  logic [B*EW-1:0] opb,
  input  logic [B-1:0]    pred,
  input  logic            use_pred,
  output logic [B*EW-1:0] sum,
  output logic [B-1:0]    lane_wen
);
  function automatic logic [EW-1:0] lane_add(input logic [EW-1:0] x, input logic [EW-1:0] y);
    return x + y;
  endfunction

  for (genvar l = 0; l < B; l++) begin : g_lane
    assign sum[l*EW +: EW] = lane_add(opa[l*EW +: EW], opb[l*EW +: EW]);
    assign lane_wen[l]     = !use_pred || pred[l];
  end
endmodule

// File: rtl/vru_seq.sv
module vru_seq
  import vru_pkg::*;
#(
  parameter int VLEN = 64,
  parameter int B    = 8,
  parameter int AW   = 16,
  parameter int RW   = 3,
  parameter int GW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  vop_e            cmd_op,
  input  logic [RW-1:0]   cmd_dst,
  input  logic [RW-1:0]   cmd_srca,
  input  logic [RW-1:0]   cmd_srcb,
  input  logic [AW-1:0]   cmd_base,
  input  logic [VLEN-1:0] cmd_mask,
  output logic            cmd_ready,
  output vop_e            op_q,
  output logic [RW-1:0]   dst_q,
  output logic [RW-1:0]   sa_q,
  output logic [RW-1:0]   sb_q,
  output logic [GW-1:0]   grp,
  output logic [B-1:0]    pred_grp,
  output logic            running,
  output logic            ld_pend,
  output logic [GW-1:0]   ld_grp,
  output logic            done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr
);
  localparam int NGRP = beat_count(VLEN, B);

  vst_e            st;
  logic [AW-1:0]   base_q;
  logic [VLEN-1:0] mask_q;
  logic            accept;
  logic            last_grp;
  logic            is_mem_op;

  assign accept    = cmd_valid && (st == S_IDLE);
  assign last_grp  = (grp == GW'(NGRP - 1));
  assign is_mem_op = (op_q == OP_VLD) || (op_q == OP_VST);
  assign cmd_ready = (st == S_IDLE);
  assign running   = (st == S_RUN);
  assign mem_req   = running && is_mem_op;
  assign mem_we    = running && (op_q == OP_VST);
  assign mem_addr  = base_q + AW'(int'(grp) * B);
  assign pred_grp  = B'(mask_q >> (int'(grp) * B));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      grp     <= '0;
      done    <= 1'b0;
      ld_pend <= 1'b0;
      ld_grp  <= '0;
      op_q    <= OP_VLD;
      dst_q   <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      base_q  <= '0;
      mask_q  <= '0;
    end else begin
      done    <= 1'b0;
      ld_pend <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op_q   <= cmd_op;
          dst_q  <= cmd_dst;
          sa_q   <= cmd_srca;
          sb_q   <= cmd_srcb;
          base_q <= cmd_base;
          mask_q <= cmd_mask;
          grp    <= '0;
          st     <= S_RUN;
        end
        S_RUN: begin
          ld_pend <= (op_q == OP_VLD);
          ld_grp  <= grp;
          if (last_grp) begin
            grp <= '0;
            if (op_q == OP_VLD) st <= S_DRAIN;
            else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end else begin
            grp <= grp + 1'b1;
          end
        end
        S_DRAIN: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Beat counter kept only for the checks below
  logic [15:0] req_seen;
  always_ff @(posedge clk) begin
    if (!rst_n || accept) req_seen <= '0;
    else if (mem_req)     req_seen <= req_seen + 16'd1;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
  assert_contig_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + AW'(B)));
  assert_beat_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_mem_op) |-> (req_seen == 16'(NGRP)));
  assert_load_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pend |-> $past(mem_req && !mem_we));
endmodule

// File: rtl/vru_top.sv
module vru_top
  import vru_pkg::*;
#(
  parameter int NREG = 8,
  parameter int VLEN = 64,
  parameter int EW   = 16,
  parameter int B    = 8,
  parameter int AW   = 16,
  localparam int RW   = $clog2(NREG),
  localparam int NGRP = VLEN / B,
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int BW   = B * EW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [RW-1:0]   cmd_dst,
  input  logic [RW-1:0]   cmd_srca,
  input  logic [RW-1:0]   cmd_srcb,
  input  logic [AW-1:0]   cmd_base,
  input  logic [VLEN-1:0] cmd_mask,
  output logic            cmd_ready,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata,
  output logic            done
);
  vop_e          op_q;
  logic [RW-1:0] dst_q, sa_q, sb_q;
  logic [GW-1:0] grp, ld_grp, wgrp;
  logic [B-1:0]  pred_grp, lane_wen, wen;
  logic          running, ld_pend, arith_wr, rf_we;
  logic [BW-1:0] ra_data, rb_data, sum, wdata;

  vru_seq #(.VLEN(VLEN), .B(B), .AW(AW), .RW(RW), .GW(GW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(vop_e'(cmd_op)),
    .cmd_dst(cmd_dst), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb),
    .cmd_base(cmd_base), .cmd_mask(cmd_mask), .cmd_ready(cmd_ready),
    .op_q(op_q), .dst_q(dst_q), .sa_q(sa_q), .sb_q(sb_q), .grp(grp),
    .pred_grp(pred_grp), .running(running), .ld_pend(ld_pend), .ld_grp(ld_grp),
    .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
  );

  vru_lanes #(.EW(EW), .B(B)) u_lanes (
    .opa(ra_data), .opb(rb_data), .pred(pred_grp),
    .use_pred(op_q == OP_VCADD), .sum(sum), .lane_wen(lane_wen)
  );

  assign arith_wr  = running && ((op_q == OP_VADD) || (op_q == OP_VCADD));
  assign rf_we     = ld_pend || arith_wr;
  assign wgrp      = ld_pend ? ld_grp : grp;
  assign wdata     = ld_pend ? mem_rdata : sum;
  assign wen       = ld_pend ? {B{1'b1}} : lane_wen;
  assign mem_wdata = ra_data;

  vru_rf #(.NREG(NREG), .VLEN(VLEN), .EW(EW), .B(B), .RW(RW), .GW(GW)) u_rf (
    .clk(clk), .we(rf_we), .widx(dst_q), .wgrp(wgrp), .wen(wen), .wdata(wdata),
    .ra_idx(sa_q), .rb_idx(sb_q), .rgrp(grp), .ra_data(ra_data), .rb_data(rb_data)
  );

  assert_no_write_in_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !rf_we);
endmodule

// File: tb/tb_vru_top.sv
`timescale 1ns/1ps
module tb_vru_top;
  localparam int NREG = 8, VLEN = 64, EW = 16, B = 8, AW = 16;
  localparam int NG = VLEN / B;
  localparam int MD = 1024;
  localparam int STB = 512;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_op = 2'b00;
  logic [2:0]        cmd_dst = '0, cmd_srca = '0, cmd_srcb = '0;
  logic [AW-1:0]     cmd_base = '0;
  logic [VLEN-1:0]   cmd_mask = '0;
  logic              cmd_ready, mem_req, mem_we, done;
  logic [AW-1:0]     mem_addr;
  logic [B*EW-1:0]   mem_wdata;
  logic [B*EW-1:0]   mem_rdata = '0;

  logic [EW-1:0] mem [MD];
  logic [EW-1:0] mdl [NREG][VLEN];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  vru_top #(.NREG(NREG), .VLEN(VLEN), .EW(EW), .B(B), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_dst(cmd_dst), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb),
    .cmd_base(cmd_base), .cmd_mask(cmd_mask), .cmd_ready(cmd_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
  );

  // Memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      for (int l = 0; l < B; l++) begin
        if (mem_we) mem[(int'(mem_addr) + l) % MD] <= mem_wdata[l*EW +: EW];
        else mem_rdata[l*EW +: EW] <= mem[(int'(mem_addr) + l) % MD];
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input int d, input int a, input int b,
                        input int base, input logic [63:0] m,
                        input bit intrude, input int intr_dst);
    int cyc, reqk, lat;
    bit seen;
    lat = (op == 2'b00) ? NG + 1 : NG;
    @(negedge clk);
    chk("R2 ready before issue", 64'(cmd_ready), 64'd1);
    cmd_op = op; cmd_dst = 3'(d); cmd_srca = 3'(a); cmd_srcb = 3'(b);
    cmd_base = AW'(base); cmd_mask = m; cmd_valid = 1'b1;
    @(posedge clk);
    if (intrude) begin
      @(negedge clk);
      cmd_op = 2'b10; cmd_dst = 3'(intr_dst); cmd_srca = 3'd0; cmd_srcb = 3'd1;
    end
    else #1 cmd_valid = 1'b0;
    cyc = 0; reqk = 0; seen = 0;
    while (cyc < 300) begin
      if (!(intrude && cyc == 0)) @(negedge clk);
      if (done) begin seen = 1; break; end
      if (cmd_ready) chk("R2 ready low while busy", 64'(cmd_ready), 64'd0);
      if (mem_req) begin
        chk("R5 beat address", 64'(mem_addr), 64'(base + reqk * B));
        chk("R5 write enable", 64'(mem_we), 64'(op == 2'b01));
        reqk++;
      end
      if (cyc >= NG - 1) cmd_valid = 1'b0;
      @(posedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    if (!seen) begin n_bad++; $display("FAIL R8 watchdog: no done"); end
    chk("R8 done latency", 64'(cyc), 64'(lat));
    chk("R5 request count", 64'(reqk), (op[1] == 1'b0) ? 64'(NG) : 64'd0);
    @(negedge clk);
    chk("R8 done one cycle", 64'(done), 64'd0);
    // model update from the requirements
    for (int i = 0; i < VLEN; i++) begin
      if (op == 2'b00) mdl[d][i] = mem[(base + i) % MD];
      else if (op == 2'b10 || (op == 2'b11 && m[i]))
        mdl[d][i] = EW'(32'(mdl[a][i]) + 32'(mdl[b][i]));
    end
  endtask

  task automatic verify_reg(input int r, input string req);
    run_op(2'b01, 0, r, 0, STB, '0, 1'b0, 0);
    @(negedge clk);
    for (int i = 0; i < VLEN; i++) chk(req, 64'(mem[STB + i]), 64'(mdl[r][i]));
  endtask

  task automatic verify_all(input string req);
    for (int r = 0; r < NREG; r++) verify_reg(r, req);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] masks [6];
    masks[0] = 64'h0;
    masks[1] = '1;
    masks[2] = 64'h5555_5555_5555_5555;
    masks[3] = 64'h8000_0000_0000_0001;
    masks[4] = 64'h0123_4567_89AB_CDEF;
    masks[5] = 64'hFFFF_0000_FFFF_0000;
    for (int i = 0; i < MD; i++) mem[i] = EW'(i * 2731 + 40000);
    for (int i = 0; i < VLEN; i++) begin
      mem[768 + i] = 16'hFFFF;
      mem[832 + i] = EW'(i + 1);
    end

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", 64'(cmd_ready), 64'd1);
    chk("R1 done in reset", 64'(done), 64'd0);
    chk("R1 req in reset", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(cmd_ready), 64'd1);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 req after reset", 64'(mem_req), 64'd0);

    // R3 load all registers, R4 store back
    for (int r = 0; r < NREG; r++) run_op(2'b00, r, 0, 0, r * 64, '0, 1'b0, 0);
    verify_all("R3 load/R4 store element");

    // R6 add sweep over register pairs
    for (int k = 0; k < NREG; k++) run_op(2'b10, k, (k + 1) % NREG, (k + 2) % NREG, 0, '0, 1'b0, 0);
    verify_all("R6 add element");

    // R6 explicit wrap: 0xFFFF + (i+1)
    run_op(2'b00, 6, 0, 0, 768, '0, 1'b0, 0);
    run_op(2'b00, 7, 0, 0, 832, '0, 1'b0, 0);
    run_op(2'b10, 5, 6, 7, 0, '0, 1'b0, 0);
    verify_reg(5, "R6 wrap element");
    chk("R6 wrap value elem0", 64'(mem[STB]), 64'd0);

    // R9 in-place add
    run_op(2'b10, 3, 3, 3, 0, '0, 1'b0, 0);
    verify_reg(3, "R9 in-place element");
    run_op(2'b11, 4, 4, 2, 0, masks[4], 1'b0, 0);
    verify_reg(4, "R9 in-place masked element");

    // R7 masked add with several predicates
    for (int k = 0; k < 6; k++) begin
      run_op(2'b11, k % NREG, (k + 3) % NREG, (k + 5) % NREG, 0, masks[k], 1'b0, 0);
      verify_reg(k % NREG, "R7 masked element");
    end

    // R2 command raised while busy must be ignored
    run_op(2'b01, 0, 2, 0, STB, '0, 1'b1, 4);
    verify_reg(4, "R2 busy command ignored");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule